// File: doc/BRIEF.md
# Reset-Time Monitor Mode Selector

This block decides, once per reset, how the chip comes up. It looks at the three-level interrupt pin, the flag that says whether the reset vector is erased, the serial line and three strap pins. On the clock edge at which synchronous reset is released, it latches one of four operating modes:

- user
- normal monitor
- blank-vector monitor
- forced monitor

Along with the mode it latches the matching watchdog enable, internal clock generator enable and bus clock divide ratio.

After that edge the latched setting holds until the next reset, whatever the pins do. A small divider then produces a one-cycle bus enable every 2 or 4 input clocks. From that enable it derives a serial bit-rate tick every 256 bus enables, so a 2.4576 MHz bus gives 9600 baud.

The following are handled outside the block: detecting the test voltage on the interrupt pin, the monitor firmware and the serial data path. The interrupt pin arrives already encoded as a 2-bit level.

Top module: `mon_mode_sel`

## Requirements
- R1: Interrupt level code 2'b10 (test voltage) together with serial line high, strap 0 high and strap 1 low latches normal monitor mode (mode code 2'b01).
- R2: In normal monitor mode, divider pin low gives a ÷2 bus (div4_sel = 0) and divider pin high gives a ÷4 bus (div4_sel = 1).
- R3: Interrupt level 2'b01 (VDD) or 2'b11 (reserved, treated as VDD) with the vector erased latches blank-vector monitor (mode 2'b10) with div4_sel = 1, whatever the serial line and strap pins are.
- R4: Interrupt level 2'b00 (VSS) with the vector erased latches forced monitor (mode 2'b11) with icg_en = 1 and div4_sel = 0.
- R5: With the vector not erased and no test voltage, the block latches user mode (mode 2'b00) with cop_en = 1, icg_en = 1 and div4_sel = 0.
- R6: Test voltage with any strap/serial pattern other than the one in R1 is decoded as VDD: blank-vector monitor if the vector is erased, user mode otherwise.
- R7: In every monitor mode cop_en = 0. In normal and blank-vector monitor mode icg_en = 0.
- R8: mode, cop_en, icg_en and div4_sel are captured on the clock edge at which rst falls, and then stay constant until rst is asserted again.
- R9: After capture, bus_en is a single-cycle pulse every 2 input clocks (div4_sel = 0) or every 4 (div4_sel = 1).
- R10: baud_tick is a single-cycle pulse that coincides with bus_en, once every 256 bus enables. Consecutive ticks are therefore 512 or 1024 clocks apart.
- R11: While rst is high, mode = 2'b00, cop_en = icg_en = div4_sel = 0, and bus_en and baud_tick stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_lvl | input | 2 | Interrupt pin level: 00 VSS, 01 VDD, 10 test voltage, 11 reserved |
| vec_blank | input | 1 | High when the reset vector reads erased |
| ser_line | input | 1 | Level of the serial line |
| mode_pin0 | input | 1 | Strap pin 0 |
| mode_pin1 | input | 1 | Strap pin 1 |
| div_pin | input | 1 | Divider select strap, used in normal monitor mode |
| mode | output | 2 | Latched mode: 00 user, 01 normal, 10 blank-vector, 11 forced |
| cop_en | output | 1 | Watchdog enable |
| icg_en | output | 1 | Internal clock generator enable |
| div4_sel | output | 1 | 1 = bus is input ÷4, 0 = ÷2 |
| bus_en | output | 1 | One-cycle bus clock enable |
| baud_tick | output | 1 | One-cycle serial bit tick |

## Verification
A wrong decode or a capture on the wrong edge shows on mode, cop_en, icg_en and div4_sel one clock after rst falls. If the capture register also follows later pin changes, the error shows as soon as the pins move after reset.

A wrong divider state shows within four clocks as a miscounted bus_en rate. A wrong bit-rate counter only shows at the next baud_tick, up to 1024 clocks later. The bench therefore measures whole tick-to-tick intervals rather than single pulses.

// File: rtl/mon_sel_pkg.sv
package mon_sel_pkg;

  typedef enum logic [1:0] {
    MODE_USER   = 2'b00,
    MODE_NORMAL = 2'b01,
    MODE_BLANK  = 2'b10,
    MODE_FORCED = 2'b11
  } mon_mode_e;

  localparam logic [1:0] IRQ_VSS  = 2'b00;
  localparam logic [1:0] IRQ_VDD  = 2'b01;
  localparam logic [1:0] IRQ_TEST = 2'b10;
  localparam logic [1:0] IRQ_RSVD = 2'b11;

  typedef struct packed {
    mon_mode_e mode;
    logic      cop_en;
    logic      icg_en;
    logic      div4;
  } mon_cfg_t;

  // True when straps and serial line carry the normal-monitor entry pattern.
  function automatic logic entry_pattern(input logic ser, input logic p0,
                                         input logic p1);
    return ser & p0 & ~p1;
  endfunction

  // Full reset-time decision; reserved and unmatched test levels act as VDD.
  function automatic mon_cfg_t decode_cfg(input logic [1:0] irq,
                                          input logic blank,
                                          input logic ser, input logic p0,
                                          input logic p1, input logic dpin);
    mon_cfg_t c;
    c.mode   = MODE_USER;
    c.cop_en = 1'b1;
    c.icg_en = 1'b1;
    c.div4   = 1'b0;
    if (irq == IRQ_TEST && entry_pattern(ser, p0, p1)) begin
      c.mode   = MODE_NORMAL;
      c.cop_en = 1'b0;
      c.icg_en = 1'b0;
      c.div4   = dpin;
    end else if (blank) begin
      if (irq == IRQ_VSS) begin
        c.mode   = MODE_FORCED;
        c.cop_en = 1'b0;
        c.icg_en = 1'b1;
        c.div4   = 1'b0;
      end else begin
        c.mode   = MODE_BLANK;
        c.cop_en = 1'b0;
        c.icg_en = 1'b0;
        c.div4   = 1'b1;
      end
    end
    return c;
  endfunction

  // Input clocks per bus enable.
  function automatic int unsigned bus_ratio(input logic div4, input int unsigned lo,
                                            input int unsigned hi);
    return div4 ? hi : lo;
  endfunction

endpackage

// File: rtl/mon_mode_decode.sv
module mon_mode_decode
  import mon_sel_pkg::*;
(
  input  logic [1:0] irq_lvl,
  input  logic       vec_blank,
  input  logic       ser_line,
  input  logic       mode_pin0,
  input  logic       mode_pin1,
  input  logic       div_pin,
  output mon_cfg_t   cfg,
  output logic       normal_pat
);

  assign normal_pat = (irq_lvl == IRQ_TEST) && entry_pattern(ser_line, mode_pin0, mode_pin1);

  always_comb begin
    cfg = decode_cfg(irq_lvl, vec_blank, ser_line, mode_pin0, mode_pin1, div_pin);
  end

  // R4
  always_comb begin
    forced_src_chk: assert (!(cfg.mode == MODE_FORCED) || (irq_lvl == IRQ_VSS && vec_blank))
      else $error("forced mode without VSS level and blank vector");
  end

endmodule

// File: rtl/mon_cfg_latch.sv
module mon_cfg_latch
  import mon_sel_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  mon_cfg_t cfg_in,
  output mon_cfg_t cfg_q,
  output logic     valid_q,
  output logic     capture
);

  logic rst_q;

  assign capture = rst_q & ~rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_q   <= 1'b1;
      valid_q <= 1'b0;
      cfg_q   <= '0;
    end else begin
      rst_q <= 1'b0;
      if (capture) begin
        cfg_q   <= cfg_in;
        valid_q <= 1'b1;
      end
    end
  end

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> $stable(cfg_q))
    else $error("latched configuration changed without reset");

  // R8
  capture_once_chk: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> !capture)
    else $error("second capture without reset");

endmodule

// File: rtl/mon_clk_div.sv
module mon_clk_div #(
  parameter int unsigned BUS_RATIO_LO = 2,
  parameter int unsigned BUS_RATIO_HI = 4,
  parameter int unsigned BAUD_DIV     = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic div4,
  output logic bus_en,
  output logic baud_tick
);

  localparam int unsigned CW = (BUS_RATIO_HI > 1) ? $clog2(BUS_RATIO_HI) : 1;
  localparam int unsigned BW = (BAUD_DIV > 1) ? $clog2(BAUD_DIV) : 1;

  logic [CW-1:0] div_cnt;
  logic [CW-1:0] div_last;
  logic [BW-1:0] baud_cnt;
  logic          baud_wrap;

  assign div_last  = div4 ? CW'(BUS_RATIO_HI - 1) : CW'(BUS_RATIO_LO - 1);
  assign bus_en    = run && (div_cnt == div_last);
  assign baud_wrap = (baud_cnt == BW'(BAUD_DIV - 1));
  assign baud_tick = bus_en && baud_wrap;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      div_cnt <= '0;
    end else if (bus_en) begin
      div_cnt <= '0;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      baud_cnt <= '0;
    end else if (bus_en) begin
      baud_cnt <= baud_wrap ? '0 : baud_cnt + 1'b1;
    end
  end

  // R9
  bus_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    bus_en |=> !bus_en)
    else $error("bus enable held two cycles");

  // R9
  bus_div4_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_en && div4) |=> !bus_en ##1 !bus_en ##1 !bus_en)
    else $error("bus enable too frequent in divide-by-4");

  // R10
  baud_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    baud_tick |=> !baud_tick)
    else $error("baud tick held two cycles");

endmodule

// File: rtl/mon_mode_sel.sv
module mon_mode_sel
  import mon_sel_pkg::*;
#(
  parameter int unsigned BUS_RATIO_LO = 2,
  parameter int unsigned BUS_RATIO_HI = 4,
  parameter int unsigned BAUD_DIV     = 256
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] irq_lvl,
  input  logic       vec_blank,
  input  logic       ser_line,
  input  logic       mode_pin0,
  input  logic       mode_pin1,
  input  logic       div_pin,
  output logic [1:0] mode,
  output logic       cop_en,
  output logic       icg_en,
  output logic       div4_sel,
  output logic       bus_en,
  output logic       baud_tick
);

  mon_cfg_t cfg_dec;
  mon_cfg_t cfg_q;
  logic     normal_pat;
  logic     cfg_valid;
  logic     cfg_capture;

  mon_mode_decode u_decode (
    .irq_lvl    (irq_lvl),
    .vec_blank  (vec_blank),
    .ser_line   (ser_line),
    .mode_pin0  (mode_pin0),
    .mode_pin1  (mode_pin1),
    .div_pin    (div_pin),
    .cfg        (cfg_dec),
    .normal_pat (normal_pat)
  );

  mon_cfg_latch u_latch (
    .clk     (clk),
    .rst     (rst),
    .cfg_in  (cfg_dec),
    .cfg_q   (cfg_q),
    .valid_q (cfg_valid),
    .capture (cfg_capture)
  );

  mon_clk_div #(
    .BUS_RATIO_LO (BUS_RATIO_LO),
    .BUS_RATIO_HI (BUS_RATIO_HI),
    .BAUD_DIV     (BAUD_DIV)
  ) u_div (
    .clk       (clk),
    .rst       (rst),
    .run       (cfg_valid),
    .div4      (cfg_q.div4),
    .bus_en    (bus_en),
    .baud_tick (baud_tick)
  );

  assign mode     = cfg_q.mode;
  assign cop_en   = cfg_q.cop_en;
  assign icg_en   = cfg_q.icg_en;
  assign div4_sel = cfg_q.div4;

  // R1
  normal_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_capture && normal_pat) |=> (mode == MODE_NORMAL))
    else $error("entry pattern did not select normal monitor");

  // R7
  mon_cop_off_chk: assert property (@(posedge clk) disable iff (rst)
    (mode != MODE_USER) |-> !cop_en)
    else $error("watchdog enabled in a monitor mode");

  // R5
  user_cop_on_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && mode == MODE_USER) |-> (cop_en && icg_en && !div4_sel))
    else $error("user mode with wrong enables");

  // R4
  forced_icg_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_FORCED) |-> (icg_en && !div4_sel))
    else $error("forced monitor without internal clock");

  // R11
  idle_in_reset_chk: assert property (@(posedge clk)
    $past(rst) && rst |-> (!bus_en && !baud_tick && mode == MODE_USER))
    else $error("activity while in reset");

endmodule

// File: tb/mon_mode_sel_tb.sv
module mon_mode_sel_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] irq_lvl = 2'b00;
  logic       vec_blank = 1'b0;
  logic       ser_line = 1'b0;
  logic       mode_pin0 = 1'b0;
  logic       mode_pin1 = 1'b0;
  logic       div_pin = 1'b0;
  logic [1:0] mode;
  logic       cop_en, icg_en, div4_sel, bus_en, baud_tick;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  int unsigned cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mon_mode_sel dut_i (
    .clk(clk), .rst(rst), .irq_lvl(irq_lvl), .vec_blank(vec_blank),
    .ser_line(ser_line), .mode_pin0(mode_pin0), .mode_pin1(mode_pin1),
    .div_pin(div_pin), .mode(mode), .cop_en(cop_en), .icg_en(icg_en),
    .div4_sel(div4_sel), .bus_en(bus_en), .baud_tick(baud_tick)
  );

  task automatic chk(input string req, input string what,
                     input int unsigned act, input int unsigned exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Hold reset with the given pins, release it, and stop one negedge after capture.
  task automatic boot(input logic [1:0] irq, input logic blank, input logic ser,
                      input logic p0, input logic p1, input logic dp);
    @(negedge clk);
    rst = 1'b1;
    irq_lvl = irq; vec_blank = blank; ser_line = ser;
    mode_pin0 = p0; mode_pin1 = p1; div_pin = dp;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic chk_cfg(input string req, input int unsigned m, input logic cop,
                         input logic icg, input logic d4);
    chk(req, "mode", mode, m);
    chk(req, "cop_en", cop_en, cop);
    chk(req, "icg_en", icg_en, icg);
    chk(req, "div4_sel", div4_sel, d4);
  endtask

  task automatic count_bus(input string req, input int unsigned ncyc,
                           input int unsigned exp);
    int unsigned n = 0;
    for (int i = 0; i < int'(ncyc); i++) begin
      if (bus_en) n++;
      @(negedge clk);
    end
    chk(req, "bus_en count", n, exp);
  endtask

  task automatic baud_gap(input string req, input int unsigned exp);
    int unsigned t0, t1;
    logic with_bus;
    while (!baud_tick) @(negedge clk);
    with_bus = bus_en;
    t0 = cyc;
    @(negedge clk);
    while (!baud_tick) @(negedge clk);
    t1 = cyc;
    chk(req, "tick coincides with bus_en", with_bus, 1);
    chk(req, "tick interval", t1 - t0, exp);
  endtask

  task automatic t_reset_state();
    rst = 1'b1;
    irq_lvl = 2'b10; ser_line = 1'b1; mode_pin0 = 1'b1; vec_blank = 1'b1;
    repeat (4) @(negedge clk);
    chk_cfg("R11", 0, 0, 0, 0);
    chk("R11", "bus_en", bus_en, 0);
    chk("R11", "baud_tick", baud_tick, 0);
  endtask

  task automatic t_normal_div2();
    boot(2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    chk_cfg("R1", 1, 0, 0, 0);
    count_bus("R9", 64, 32);
    baud_gap("R10", 512);
  endtask

  task automatic t_normal_div4();
    boot(2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
    chk_cfg("R2", 1, 0, 0, 1);
    count_bus("R9", 64, 16);
    baud_gap("R10", 1024);
  endtask

  task automatic t_blank_vdd();
    boot(2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    chk_cfg("R3", 2, 0, 0, 1);
    count_bus("R3", 32, 8);
    boot(2'b11, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    chk_cfg("R3", 2, 0, 0, 1);
  endtask

  task automatic t_forced();
    boot(2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
    chk_cfg("R4", 3, 0, 1, 0);
    chk("R7", "cop_en forced", cop_en, 0);
    count_bus("R4", 32, 16);
  endtask

  task automatic t_user();
    boot(2'b01, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    chk_cfg("R5", 0, 1, 1, 0);
    boot(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk_cfg("R5", 0, 1, 1, 0);
  endtask

  task automatic t_test_fallback();
    boot(2'b10, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    chk_cfg("R6", 2, 0, 0, 1);
    boot(2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk_cfg("R6", 0, 1, 1, 0);
  endtask

  task automatic t_hold();
    boot(2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    chk_cfg("R8", 1, 0, 0, 1);
    irq_lvl = 2'b00; vec_blank = 1'b1; ser_line = 1'b0;
    mode_pin0 = 1'b0; mode_pin1 = 1'b1; div_pin = 1'b0;
    repeat (10) @(negedge clk);
    chk_cfg("R8", 1, 0, 0, 1);
    count_bus("R8", 32, 8);
  endtask

  initial begin
    fork
      begin
        t_reset_state();
        t_normal_div2();
        t_normal_div4();
        t_blank_vdd();
        t_forced();
        t_user();
        t_test_fallback();
        t_hold();
      end
      begin
        repeat (150000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule